// File: doc/BRIEF.md
# Cascadable LCD Column Data Loader

This block is the digital core of an 80-column segment driver for a multiplexed dot-matrix LCD. A display controller sends one line of pixel bits serially, together with a shift clock. The block collects the bits into groups of four. Each complete group is written into a first-stage column register through one of twenty decoded group strobes. A line clock then copies the whole first-stage register into a second-stage register, which drives the columns. For each column, the block produces a 2-bit code that chooses one of four drive levels. The code depends on the column's pixel bit and on an AC-inversion phase input.

A direction input selects both the serial pin and the fill order. With the direction input low, data enters on the left pin and fills columns from 0 upward. With it high, data enters on the right pin and fills columns from 79 downward. Several loaders can share one serial stream by connecting the carry output of each stage to the enable input of the next. A stage takes bits only while it is armed and its enable input is low. Once it has taken its 80th bit, it disarms itself and drops its carry, so the following stage begins to take bits.

All controller-side inputs are asynchronous to `clk`. Each passes through a two-flop synchroniser, and edges are found by comparing successive samples. For this reason `clk` must run at least four times faster than the shift clock.

Top module: `lcd_col_loader`

## Requirements
- R1: After reset, every first- and second-stage bit is 0, the loader is disarmed, and `carry_out` is 1. With `ac_phase` low, every column code therefore reads 2'b11.
- R2: With `dir_rev` low, each falling edge of `shift_clk` takes one bit from `data_l`. The k-th bit taken (k = 0..79) lands in column k, whose code occupies `lvl_out[2k+1:2k]`.
- R3: With `dir_rev` high, each bit is taken from `data_r`, and `data_l` has no effect. The k-th bit taken lands in column 79-k.
- R4: Column codes change only after a falling edge of `line_clk`. At that edge the whole first stage is copied into the second stage, and bits taken earlier on the same line leave the outputs unchanged.
- R5: The column code is 2'b00 for bit 1 with `ac_phase` 1, 2'b01 for bit 1 with `ac_phase` 0, 2'b10 for bit 0 with `ac_phase` 1, and 2'b11 for bit 0 with `ac_phase` 0.
- R6: `carry_out` goes to 0 once the 80th bit of a line has been taken. It returns to 1 on the next rising edge of `line_clk`.
- R7: Shift edges after the 80th bit and before the next high level of `line_clk` change no column.
- R8: While `chain_en_n` is 1, shift edges take no bits, leave the first stage unchanged, and do not move `carry_out`. Bits are taken again as soon as `chain_en_n` returns to 0.
- R9: While `line_clk` is high, the bit counter is cleared and the loader is armed; arming takes priority over disarming. A loader that has not been armed since reset takes no bits.
- R10: Bits are written to the first stage only as complete groups of four. A trailing group with fewer than four bits leaves its columns unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the shift clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| line_clk | input | 1 | Line clock: high level clears and arms, falling edge transfers to outputs |
| shift_clk | input | 1 | Serial shift clock; a bit is taken on its falling edge |
| data_l | input | 1 | Serial data pin used when `dir_rev` is 0 |
| data_r | input | 1 | Serial data pin used when `dir_rev` is 1 |
| dir_rev | input | 1 | Direction select: 0 fills columns 0..79, 1 fills 79..0 |
| chain_en_n | input | 1 | Active-low enable; connect to the previous stage's `carry_out` |
| ac_phase | input | 1 | AC-inversion phase of the drive waveform |
| carry_out | output | 1 | Goes low when this stage is full; connect to the next stage's enable |
| lvl_out | output | 160 | 2-bit drive-level code per column, column c at bits [2c+1:2c] |

## Verification
The bench targets the boundaries of a line. Near the 80th bit, a loader that counts one bit too many or too few would drop the carry early or late, or would let surplus bits overwrite columns. In reverse mode it checks the mapping of each column. A mirrored group or bit order shows up as scrambled columns, and a loader that reads the wrong pin takes the inverted decoy data driven on the unused pin. It also covers a line cut short by a line pulse, a trailing partial group, and enable gating in the middle of a line. A counter that is not cleared, or a loader that writes partial groups or ignores the enable, leaves visibly wrong columns after the next line transfer.

// File: rtl/lcdl_pkg.sv
// Package: shared constants, level-code type and helper for the column loader.
// Assumes a 2-bit code per column; the encoding is fixed by the requirements.
package lcdl_pkg;

    localparam int LVL_W = 2;

    typedef enum logic [LVL_W-1:0] {
        LV_ON_POS  = 2'b00,
        LV_ON_NEG  = 2'b01,
        LV_OFF_POS = 2'b10,
        LV_OFF_NEG = 2'b11
    } lvl_e;

    // Map a pixel bit and the AC phase to a drive-level code.
    function automatic lvl_e lvl_code(input logic pix, input logic phase);
        lvl_e r;
        case ({pix, phase})
            2'b11:   r = LV_ON_POS;
            2'b10:   r = LV_ON_NEG;
            2'b01:   r = LV_OFF_POS;
            default: r = LV_OFF_NEG;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lcdl_sync.sv
// Module: multi-bit level synchroniser.
// Each bit is treated as an independent asynchronous level; no bus coherence
// is assumed across bits. Output is the value after STAGES flops.
module lcdl_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] pipe;

    // Shift the input levels through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/lcdl_gather.sv
// Module: serial-to-group gatherer and first-stage column register.
// Counts bits taken on shift falling edges, assembles GRP-bit groups and
// writes each completed group through one of NG decoded strobes. Holds the
// set-priority arm flop and the chain carry. Assumes synchronised inputs
// and a static direction select during a line.
module lcdl_gather #(
    parameter int COLS = 80,
    parameter int GRP  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_lvl,
    input  logic            shift_lvl,
    input  logic            bit_l,
    input  logic            bit_r,
    input  logic            rev,
    input  logic            en_n,
    output logic [COLS-1:0] stage1,
    output logic            carry_out
);

    localparam int NG    = COLS / GRP;
    localparam int CNT_W = $clog2(COLS + 1);
    localparam int SUB_W = $clog2(GRP);
    localparam int GI_W  = CNT_W - SUB_W;

    logic              line_prev;
    logic              shift_prev;
    logic              armed;
    logic [CNT_W-1:0]  cnt;
    logic [GRP-2:0]    nib;
    logic [GRP-1:0]    nib_full;
    logic [GRP-1:0]    nib_rev;
    logic [NG-1:0]     stb;
    logic [SUB_W-1:0]  sub;
    logic [GI_W-1:0]   grp;
    logic              take;
    logic              grp_done;
    logic              last_bit;
    logic              line_rise;
    logic              bit_in;

    // Edge history of the line and shift levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_prev  <= 1'b0;
            shift_prev <= 1'b0;
        end else begin
            line_prev  <= line_lvl;
            shift_prev <= shift_lvl;
        end
    end

    // Decode the bit-take condition and the position within the line.
    always_comb begin
        line_rise = line_lvl & ~line_prev;
        take      = shift_prev & ~shift_lvl & armed & ~en_n & ~line_lvl;
        bit_in    = rev ? bit_r : bit_l;
        sub       = cnt[SUB_W-1:0];
        grp       = cnt[CNT_W-1:SUB_W];
        grp_done  = take && (sub == SUB_W'(GRP - 1));
        last_bit  = take && (cnt == CNT_W'(COLS - 1));
        nib_full  = {bit_in, nib};
        for (int j = 0; j < GRP; j++) begin
            nib_rev[j] = nib_full[GRP-1-j];
        end
    end

    // Group strobe decoder: one strobe per completed group.
    always_comb begin
        stb = '0;
        for (int g = 0; g < NG; g++) begin
            if (grp == GI_W'(g)) begin
                stb[g] = grp_done;
            end
        end
    end

    // Bit counter: cleared while the line level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (line_lvl) begin
            cnt <= '0;
        end else if (take) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Partial-group holding register for the first GRP-1 bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nib <= '0;
        end else if (take) begin
            for (int i = 0; i < GRP - 1; i++) begin
                if (sub == SUB_W'(i)) begin
                    nib[i] <= bit_in;
                end
            end
        end
    end

    // Arm flop: set while line is high, set wins over the end-of-line reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (line_lvl) begin
            armed <= 1'b1;
        end else if (last_bit) begin
            armed <= 1'b0;
        end
    end

    // Chain carry: high on line rise, low once the last bit is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_out <= 1'b1;
        end else if (line_rise) begin
            carry_out <= 1'b1;
        end else if (last_bit) begin
            carry_out <= 1'b0;
        end
    end

    // First-stage slots: each slot is written by its forward or mirrored strobe.
    genvar s;
    generate
        for (s = 0; s < NG; s++) begin : g_slot
            logic [GRP-1:0] slot_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot_q <= '0;
                end else if (!rev && stb[s]) begin
                    slot_q <= nib_full;
                end else if (rev && stb[NG-1-s]) begin
                    slot_q <= nib_rev;
                end
            end
            assign stage1[s*GRP +: GRP] = slot_q;
        end
    endgenerate

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(COLS)); // R7

    AST_FULL_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_W'(COLS)) |-> !armed); // R7

    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb)); // R10

    AST_CARRY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(carry_out) |-> (cnt == CNT_W'(COLS))); // R6

    AST_CARRY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carry_out) |-> $past(line_lvl)); // R6

    AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> $stable(stage1)); // R8

endmodule

// File: rtl/lcdl_drive.sv
// Module: second-stage column register and per-column level encoder.
// Copies the first stage on each line falling edge and maps every column
// bit with the AC phase to a 2-bit level code. Assumes synchronised inputs.
module lcdl_drive
    import lcdl_pkg::*;
#(
    parameter int COLS = 80
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_lvl,
    input  logic                  ac_lvl,
    input  logic [COLS-1:0]       stage1,
    output logic [LVL_W*COLS-1:0] lvl_out
);

    logic            line_prev;
    logic            line_fall;
    logic [COLS-1:0] stage2;

    assign line_fall = line_prev & ~line_lvl;

    // Line edge history and second-stage capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_prev <= 1'b0;
            stage2    <= '0;
        end else begin
            line_prev <= line_lvl;
            if (line_fall) begin
                stage2 <= stage1;
            end
        end
    end

    // Per-column level encoding.
    genvar c;
    generate
        for (c = 0; c < COLS; c++) begin : g_col
            assign lvl_out[LVL_W*c +: LVL_W] = lvl_code(stage2[c], ac_lvl);
        end
    endgenerate

    AST_HOLD_STAGE2: assert property (@(posedge clk) disable iff (!rst_n)
        !line_fall |=> $stable(stage2)); // R4

    AST_LOAD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        line_fall |=> (stage2 == $past(stage1))); // R4

endmodule

// File: rtl/lcd_col_loader.sv
// Module: top of the cascadable LCD column data loader.
// Synchronises all controller-side inputs to clk, then feeds the gatherer
// and the drive stage. Assumes clk is at least 4x the shift clock rate.
module lcd_col_loader
    import lcdl_pkg::*;
#(
    parameter int COLS        = 80,
    parameter int GRP         = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_clk,
    input  logic                  shift_clk,
    input  logic                  data_l,
    input  logic                  data_r,
    input  logic                  dir_rev,
    input  logic                  chain_en_n,
    input  logic                  ac_phase,
    output logic                  carry_out,
    output logic [LVL_W*COLS-1:0] lvl_out
);

    localparam int NSYNC = 7;

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] syn;
    logic [COLS-1:0]  stage1;

    assign raw_in = {line_clk, shift_clk, data_l, data_r, dir_rev, chain_en_n, ac_phase};

    lcdl_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn)
    );

    lcdl_gather #(.COLS(COLS), .GRP(GRP)) u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_lvl  (syn[6]),
        .shift_lvl (syn[5]),
        .bit_l     (syn[4]),
        .bit_r     (syn[3]),
        .rev       (syn[2]),
        .en_n      (syn[1]),
        .stage1    (stage1),
        .carry_out (carry_out)
    );

    lcdl_drive #(.COLS(COLS)) u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_lvl (syn[6]),
        .ac_lvl   (syn[0]),
        .stage1   (stage1),
        .lvl_out  (lvl_out)
    );

endmodule

// File: tb/tb_lcd_col_loader.sv
// Directed bench for the column loader; one task per scenario.
module tb_lcd_col_loader;

    localparam int COLS = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_clk = 1'b0;
    logic shift_clk = 1'b0;
    logic data_l = 1'b0;
    logic data_r = 1'b0;
    logic dir_rev = 1'b0;
    logic chain_en_n = 1'b0;
    logic ac_phase = 1'b0;
    logic carry_out;
    logic [2*COLS-1:0] lvl_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    bit exp_s1 [COLS];
    bit exp_s2 [COLS];
    bit m_armed;
    bit m_car;
    int m_cnt;
    bit m_nib [4];

    always #2 clk = ~clk;

    lcd_col_loader dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_clk   (line_clk),
        .shift_clk  (shift_clk),
        .data_l     (data_l),
        .data_r     (data_r),
        .dir_rev    (dir_rev),
        .chain_en_n (chain_en_n),
        .ac_phase   (ac_phase),
        .carry_out  (carry_out),
        .lvl_out    (lvl_out)
    );

    function automatic bit pat(int seed, int k);
        return bit'((((k * 7 + seed) * 13) >> 2) ^ k ^ (seed >> 1));
    endfunction

    function automatic logic [1:0] exp_code(bit pix, bit ph);
        return {~pix, ~ph};
    endfunction

    task automatic check_cols(string tag);
        int nerr = 0;
        total++;
        for (int c = 0; c < COLS; c++) begin
            if (lvl_out[2*c +: 2] !== exp_code(exp_s2[c], ac_phase)) begin
                if (nerr == 0)
                    $display("FAIL %s col %0d actual=%b expected=%b", tag, c,
                             lvl_out[2*c +: 2], exp_code(exp_s2[c], ac_phase));
                nerr++;
            end
        end
        if (nerr != 0) bad++;
    endtask

    task automatic check_carry(string tag);
        total++;
        if (carry_out !== m_car) begin
            bad++;
            $display("FAIL %s carry actual=%b expected=%b", tag, carry_out, m_car);
        end
    endtask

    task automatic send_bit(bit b);
        if (dir_rev) begin data_r = b; data_l = ~b; end
        else         begin data_l = b; data_r = ~b; end
        shift_clk = 1'b1;
        repeat (4) @(negedge clk);
        shift_clk = 1'b0;
        repeat (4) @(negedge clk);
        if (m_armed && !chain_en_n) begin
            m_nib[m_cnt % 4] = b;
            if (m_cnt % 4 == 3) begin
                for (int i = 0; i < 4; i++) begin
                    int col = 4 * (m_cnt / 4) + i;
                    if (dir_rev) col = COLS - 1 - col;
                    exp_s1[col] = m_nib[i];
                end
            end
            m_cnt++;
            if (m_cnt == COLS) begin m_armed = 0; m_car = 0; end
        end
    endtask

    task automatic line_pulse();
        line_clk = 1'b1;
        repeat (6) @(negedge clk);
        m_cnt = 0; m_armed = 1; m_car = 1;
        line_clk = 1'b0;
        repeat (8) @(negedge clk);
        for (int c = 0; c < COLS; c++) exp_s2[c] = exp_s1[c];
    endtask

    // R1, R9: reset state and no loading before the first arm.
    task automatic t_reset();
        for (int c = 0; c < COLS; c++) begin exp_s1[c] = 0; exp_s2[c] = 0; end
        m_armed = 0; m_car = 1; m_cnt = 0;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_cols("R1 reset columns");
        check_carry("R1 reset carry");
        for (int k = 0; k < 8; k++) send_bit(1'b1);
        check_carry("R9 unarmed carry");
        line_pulse();
        check_cols("R9 unarmed bits not loaded");
    endtask

    // R2, R4, R6, R5: forward load of a full line.
    task automatic t_forward(int seed);
        dir_rev = 1'b0;
        repeat (4) @(negedge clk);
        for (int k = 0; k < COLS - 1; k++) send_bit(pat(seed, k));
        check_carry("R6 carry high before last bit");
        send_bit(pat(seed, COLS - 1));
        check_carry("R6 carry low after last bit");
        check_cols("R4 outputs held before line fall");
        line_pulse();
        check_cols("R2 forward load");
        check_carry("R6 carry restored on line rise");
        ac_phase = ~ac_phase;
        repeat (4) @(negedge clk);
        check_cols("R5 level codes other phase");
    endtask

    // R3: reverse direction with decoy data on the unused pin.
    task automatic t_reverse(int seed);
        dir_rev = 1'b1;
        repeat (4) @(negedge clk);
        for (int k = 0; k < COLS; k++) send_bit(pat(seed, k));
        check_carry("R6 reverse carry low");
        line_pulse();
        check_cols("R3 reverse load");
        dir_rev = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // R7: surplus bits after the 80th are ignored.
    task automatic t_overflow(int seed);
        for (int k = 0; k < COLS; k++) send_bit(pat(seed, k));
        for (int k = 0; k < 8; k++) send_bit(~pat(seed, k));
        check_carry("R7 carry stays low");
        line_pulse();
        check_cols("R7 surplus bits ignored");
    endtask

    // R8: enable high blocks loading; loading resumes when it drops mid-line.
    task automatic t_enable(int seed);
        chain_en_n = 1'b1;
        repeat (4) @(negedge clk);
        for (int k = 0; k < COLS; k++) send_bit(pat(seed, k));
        check_carry("R8 carry unmoved while disabled");
        line_pulse();
        check_cols("R8 disabled bits not loaded");
        for (int k = 0; k < 40; k++) send_bit(~pat(seed, k));
        chain_en_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int k = 0; k < COLS; k++) send_bit(pat(seed + 3, k));
        check_carry("R8 carry low after enabled line");
        line_pulse();
        check_cols("R8 load after enable drops");
    endtask

    // R9: a line pulse mid-line restarts at column 0.
    task automatic t_restart(int seed);
        for (int k = 0; k < 10; k++) send_bit(~pat(seed, k));
        line_pulse();
        for (int k = 0; k < COLS; k++) send_bit(pat(seed, k));
        line_pulse();
        check_cols("R9 restart from column 0");
    endtask

    // R10: a trailing partial group is not written.
    task automatic t_partial();
        for (int k = 0; k < 6; k++) send_bit(~exp_s1[k]);
        line_pulse();
        check_cols("R10 partial group dropped");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        line_pulse();
        t_forward(5);
        t_reverse(11);
        t_overflow(17);
        t_enable(23);
        t_restart(29);
        t_partial();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule